// File: doc/BRIEF.md
# AUX Channel Request Header Formatter

This block sits between a requester that wants to run one AUX channel transaction and a transmit engine that serialises bytes onto the wire. The requester hands over a 20-bit target address, a 4-bit command, a payload length and up to sixteen payload bytes. The block checks the request, packs it into a four-byte header, and streams the header to the transmit engine over a valid/ready handshake. For writes, the payload follows the header.

Once the stream has gone out, the block waits for the reply. The reply is a status byte plus the number of bytes the far end returned. The block folds these into an error class, a four-bit reply code and a clipped byte count, and announces the result with a one-cycle done pulse. Requests that are too long, or that carry a command it does not know, are rejected at once without sending anything.

Top module: `aux_req_fmt`

## Requirements
- R1: A request whose length is above 16 is answered with error class 4 (oversize), reply code 0 and count 0. No byte is sent, and done pulses in the second cycle after acceptance.
- R2: The block clears bit 2 of the command (the middle-of-transaction flag) and then checks it. The only accepted values are 0000 (I2C write), 0001 (I2C read), 1000 (native write) and 1001 (native read). Any other value yields error class 5 with nothing sent. The oversize check takes precedence over this check. Bit 0 of the command selects read (1) or write (0).
- R3: Stream byte 0 is address bits 7:0, and stream byte 1 is address bits 15:8.
- R4: Stream byte 2 holds the command, as given, in bits 7:4 and address bits 19:16 in bits 3:0.
- R5: Bits 3:0 of stream byte 3 hold the length minus one, or 0 for a zero-length request.
- R6: Bits 7:4 of stream byte 3 depend on the request:
  - a zero-length request carries 3;
  - a read carries 4;
  - a write carries the low four bits of 4 plus the length.
- R7: A write sends the 4 header bytes followed by the payload, in order; payload byte i is req_data[8i+7:8i]. A read sends only the 4 header bytes, and a zero-length request still sends all 4. tx_last marks the final byte. The byte and tx_last stay unchanged while tx_ready is low.
- R8: A reply status byte equal to 1, 2 or 3 gives error class 1 (timeout), 2 (flags) or 3 (general). Any other status value gives error class 0 (success).
- R9: On success the reply code is bits 7:4 of the status byte. On any error it is 0.
- R10: On success, a write reports its requested length as the count. A read reports the smaller of the returned length and its requested length. Any error reports 0.
- R11: After reset req_ready is 1, and tx_valid and done are 0. req_ready is high only while idle. done is a single-cycle pulse, one cycle after the reply is taken, and the results stay on the outputs until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | 20 | Target address |
| req_cmd | input | 4 | Request command |
| req_len | input | 5 | Payload length (0 to 31, above 16 rejected) |
| req_data | input | 128 | Payload bytes, byte i in bits 8i+7:8i |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Transmit engine takes the byte |
| tx_byte | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the stream |
| rsp_valid | input | 1 | Reply present |
| rsp_status | input | 8 | Reply status byte |
| rsp_len | input | 8 | Number of bytes returned |
| done | output | 1 | Result pulse |
| err_code | output | 3 | Error class |
| reply_code | output | 4 | Reply code |
| byte_count | output | 5 | Reported byte count |

## Verification
The bench aims at the wrap of the size nibble for long writes. Lengths 12 and 16 yield 0 and 4 there, and a design that saturated the sum or widened the nibble would emit wrong header bytes. It also covers zero-length reads and writes: a design that left out the bare-address code or dropped the fourth header byte would be caught by the stream check. Status bytes such as 0x11 and 0x20 test whether the whole byte is compared, since a design that decoded only the low nibble would report a false timeout. A read whose returned length exceeds the request, and one that falls short of it, catch a missing or inverted clip. Oversize and unknown commands, alone and together, verify that no byte leaks out and that the precedence holds.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;

    localparam int ADDR_BITS = 20;
    localparam int HDR_BYTES = 4;
    localparam logic [3:0] CMD_MOT_BIT    = 4'b0100;
    localparam logic [3:0] BARE_SIZE_CODE = 4'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_FIN
    } fmt_state_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_FLAGS    = 3'd2,
        ERR_GENERAL  = 3'd3,
        ERR_OVERSIZE = 3'd4,
        ERR_BADCMD   = 3'd5
    } fmt_err_e;

endpackage

// File: rtl/aux_req_check.sv
module aux_req_check
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = $clog2(MAX_PAY + 1)
) (
    input  logic [3:0]       cmd,
    input  logic [LEN_W-1:0] len,
    output logic             oversize,
    output logic             badcmd,
    output logic             is_write
);

    logic [3:0] base_cmd;

    always_comb begin
        base_cmd = cmd & ~CMD_MOT_BIT;
        oversize = len > LEN_W'(MAX_PAY);
        is_write = ~cmd[0];
        unique case (base_cmd)
            4'b0000, 4'b0001, 4'b1000, 4'b1001: badcmd = 1'b0;
            default:                            badcmd = 1'b1;
        endcase
    end

endmodule

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = $clog2(MAX_PAY + 1)
) (
    input  logic [ADDR_BITS-1:0]      addr,
    input  logic [3:0]                cmd,
    input  logic [LEN_W-1:0]          len,
    input  logic                      is_write,
    output logic [HDR_BYTES-1:0][7:0] hdr
);

    logic [LEN_W-1:0] len_m1;
    logic [LEN_W:0]   tx_total;
    logic [3:0]       size_nib;

    always_comb begin
        len_m1   = (len == '0) ? '0 : len - 1'b1;
        tx_total = (LEN_W + 1)'(HDR_BYTES) + {1'b0, len};
        if (len == '0)
            size_nib = BARE_SIZE_CODE;
        else if (is_write)
            size_nib = tx_total[3:0];
        else
            size_nib = 4'(HDR_BYTES);
        hdr[0] = addr[7:0];
        hdr[1] = addr[15:8];
        hdr[2] = {cmd, addr[19:16]};
        hdr[3] = {size_nib, len_m1[3:0]};
    end

endmodule

// File: rtl/aux_tx_mux.sv
module aux_tx_mux
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int IDX_W   = $clog2(HDR_BYTES + MAX_PAY)
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [HDR_BYTES-1:0][7:0] hdr,
    input  logic [MAX_PAY-1:0][7:0]   payload,
    output logic [7:0]                tx_byte
);

    localparam int N_BYTES = HDR_BYTES + MAX_PAY;

    logic [N_BYTES-1:0][7:0] stream;

    genvar g;
    generate
        for (g = 0; g < N_BYTES; g++) begin : g_stream
            if (g < HDR_BYTES) begin : g_hdr
                assign stream[g] = hdr[g];
            end else begin : g_pay
                assign stream[g] = payload[g - HDR_BYTES];
            end
        end
    endgenerate

    always_comb begin
        tx_byte = 8'h00;
        for (int i = 0; i < N_BYTES; i++) begin
            if (idx == IDX_W'(i))
                tx_byte = stream[i];
        end
    end

endmodule

// File: rtl/aux_rsp_decode.sv
module aux_rsp_decode
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = $clog2(MAX_PAY + 1)
) (
    input  logic [7:0]       status,
    input  logic [7:0]       rlen,
    input  logic [LEN_W-1:0] req_len,
    input  logic             is_write,
    output fmt_err_e         err,
    output logic [3:0]       reply,
    output logic [LEN_W-1:0] count
);

    logic [7:0] want8;
    logic [7:0] clip8;

    always_comb begin
        want8 = 8'(req_len);
        clip8 = (rlen < want8) ? rlen : want8;
        unique case (status)
            8'd1:    err = ERR_TIMEOUT;
            8'd2:    err = ERR_FLAGS;
            8'd3:    err = ERR_GENERAL;
            default: err = ERR_NONE;
        endcase
        if (err == ERR_NONE) begin
            reply = status[7:4];
            count = is_write ? req_len : LEN_W'(clip8);
        end else begin
            reply = 4'd0;
            count = '0;
        end
    end

endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    localparam int LEN_W  = $clog2(MAX_PAY + 1),
    localparam int IDX_W  = $clog2(HDR_BYTES + MAX_PAY)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_BITS-1:0]   req_addr,
    input  logic [3:0]             req_cmd,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [MAX_PAY*8-1:0]   req_data,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic [7:0]             tx_byte,
    output logic                   tx_last,
    input  logic                   rsp_valid,
    input  logic [7:0]             rsp_status,
    input  logic [7:0]             rsp_len,
    output logic                   done,
    output logic [2:0]             err_code,
    output logic [3:0]             reply_code,
    output logic [LEN_W-1:0]       byte_count
);

    typedef struct packed {
        fmt_state_e             st;
        logic [IDX_W-1:0]       idx;
        logic [ADDR_BITS-1:0]   addr;
        logic [3:0]             cmd;
        logic [LEN_W-1:0]       len;
        logic [MAX_PAY*8-1:0]   data;
        logic                   is_wr;
        fmt_err_e               err;
        logic [3:0]             reply;
        logic [LEN_W-1:0]       count;
    } fmt_regs_t;

    fmt_regs_t r_d, r_q;

    logic                      in_oversize;
    logic                      in_badcmd;
    logic                      in_is_wr;
    logic [HDR_BYTES-1:0][7:0] hdr;
    logic [MAX_PAY-1:0][7:0]   payload;
    logic [IDX_W-1:0]          last_idx;
    fmt_err_e                  dec_err;
    logic [3:0]                dec_reply;
    logic [LEN_W-1:0]          dec_count;

    aux_req_check #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_check (
        .cmd      (req_cmd),
        .len      (req_len),
        .oversize (in_oversize),
        .badcmd   (in_badcmd),
        .is_write (in_is_wr)
    );

    aux_hdr_pack #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_pack (
        .addr     (r_q.addr),
        .cmd      (r_q.cmd),
        .len      (r_q.len),
        .is_write (r_q.is_wr),
        .hdr      (hdr)
    );

    assign payload = r_q.data;

    aux_tx_mux #(.MAX_PAY(MAX_PAY), .IDX_W(IDX_W)) u_mux (
        .idx     (r_q.idx),
        .hdr     (hdr),
        .payload (payload),
        .tx_byte (tx_byte)
    );

    aux_rsp_decode #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_dec (
        .status   (rsp_status),
        .rlen     (rsp_len),
        .req_len  (r_q.len),
        .is_write (r_q.is_wr),
        .err      (dec_err),
        .reply    (dec_reply),
        .count    (dec_count)
    );

    assign last_idx = r_q.is_wr ? IDX_W'(HDR_BYTES - 1) + IDX_W'(r_q.len)
                                : IDX_W'(HDR_BYTES - 1);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.cmd   = req_cmd;
                    r_d.len   = req_len;
                    r_d.data  = req_data;
                    r_d.is_wr = in_is_wr;
                    r_d.idx   = '0;
                    if (in_oversize) begin
                        r_d.err   = ERR_OVERSIZE;
                        r_d.reply = 4'd0;
                        r_d.count = '0;
                        r_d.st    = ST_FIN;
                    end else if (in_badcmd) begin
                        r_d.err   = ERR_BADCMD;
                        r_d.reply = 4'd0;
                        r_d.count = '0;
                        r_d.st    = ST_FIN;
                    end else begin
                        r_d.st    = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (r_q.idx == last_idx)
                        r_d.st = ST_WAIT;
                    else
                        r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.err   = dec_err;
                    r_d.reply = dec_reply;
                    r_d.count = dec_count;
                    r_d.st    = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign tx_valid   = (r_q.st == ST_SEND);
    assign tx_last    = tx_valid && (r_q.idx == last_idx);
    assign done       = (r_q.st == ST_FIN);
    assign err_code   = r_q.err;
    assign reply_code = r_q.reply;
    assign byte_count = r_q.count;

endmodule

// File: rtl/aux_req_fmt_chk.sv
module aux_req_fmt_chk #(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = $clog2(MAX_PAY + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             tx_last,
    input logic             done,
    input logic [2:0]       err_code,
    input logic [3:0]       reply_code,
    input logic [LEN_W-1:0] byte_count
);

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

    p_oversize_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len > LEN_W'(MAX_PAY))) |=> (!tx_valid && done));

    p_err_no_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 3'd0) |-> (reply_code == 4'd0));

    p_err_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 3'd0) |-> (byte_count == '0));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count <= LEN_W'(MAX_PAY)));

endmodule

bind aux_req_fmt aux_req_fmt_chk #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .tx_last    (tx_last),
    .done       (done),
    .err_code   (err_code),
    .reply_code (reply_code),
    .byte_count (byte_count)
);

// File: tb/aux_req_fmt_tb.sv
module aux_req_fmt_tb;

    localparam int MAX_PAY = 16;
    localparam int LEN_W   = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [19:0]        req_addr = '0;
    logic [3:0]         req_cmd = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [MAX_PAY*8-1:0] req_data = '0;
    logic               tx_valid;
    logic               tx_ready = 1'b0;
    logic [7:0]         tx_byte;
    logic               tx_last;
    logic               rsp_valid = 1'b0;
    logic [7:0]         rsp_status = '0;
    logic [7:0]         rsp_len = '0;
    logic               done;
    logic [2:0]         err_code;
    logic [3:0]         reply_code;
    logic [LEN_W-1:0]   byte_count;

    int checks = 0;
    int bad = 0;
    logic [7:0]  exp_bytes[$];
    string       exp_btag[$];
    logic [11:0] exp_res[$];
    string       exp_rtag[$];
    bit          prev_done = 1'b0;

    always #10 clk = ~clk;

    aux_req_fmt #(.MAX_PAY(MAX_PAY)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len), .req_data(req_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len),
        .done(done), .err_code(err_code), .reply_code(reply_code), .byte_count(byte_count)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // transmit engine back-pressure pattern, changes away from both edges
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #3;
            cyc++;
            tx_ready = (cyc % 3) != 1;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid)
                check(!req_ready, "R11", "req_ready while sending", int'(req_ready), 0);
            if (tx_valid && tx_ready) begin
                if (exp_bytes.size() == 0) begin
                    check(1'b0, "R1 R2", "unexpected stream byte", int'(tx_byte), 0);
                end else begin
                    logic [7:0] eb;
                    string t;
                    eb = exp_bytes.pop_front();
                    t  = exp_btag.pop_front();
                    check(tx_byte == eb, t, "stream byte", int'(tx_byte), int'(eb));
                    check(tx_last == (exp_bytes.size() == 0), "R7", "tx_last",
                          int'(tx_last), int'(exp_bytes.size() == 0));
                end
            end
            if (done) begin
                check(!prev_done, "R11", "done longer than one cycle", 1, 0);
                check(exp_bytes.size() == 0, "R7", "bytes left at done",
                      exp_bytes.size(), 0);
                if (exp_res.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    logic [11:0] er;
                    string t;
                    er = exp_res.pop_front();
                    t  = exp_rtag.pop_front();
                    check({err_code, reply_code, byte_count} == er, t,
                          "{err,reply,count}", int'({err_code, reply_code, byte_count}),
                          int'(er));
                end
            end
            prev_done = done;
        end
    end

    task automatic run_req(input logic [19:0] a, input logic [3:0] c, input int len,
                           input logic [7:0] st, input logic [7:0] rl, input string tag);
        logic [3:0] base;
        bit is_w;
        bit sent;
        logic [3:0] lm1, szn;
        logic [2:0] e;
        logic [3:0] rp;
        int cnt;
        base = c & 4'b1011;
        is_w = !c[0];
        req_data = '0;
        for (int i = 0; i < MAX_PAY; i++)
            req_data[8*i +: 8] = 8'(a[7:0] + 8'(i * 37) + 8'(c));
        sent = 1'b0;
        if (len > MAX_PAY) begin
            e = 3'd4; rp = 4'd0; cnt = 0;
        end else if (!(base == 4'b0000 || base == 4'b0001 ||
                       base == 4'b1000 || base == 4'b1001)) begin
            e = 3'd5; rp = 4'd0; cnt = 0;
        end else begin
            sent = 1'b1;
            lm1 = (len == 0) ? 4'd0 : 4'(len - 1);
            if (len == 0)      szn = 4'd3;
            else if (is_w)     szn = 4'((4 + len) % 16);
            else               szn = 4'd4;
            exp_bytes.push_back(a[7:0]);        exp_btag.push_back({tag, " R3 byte0"});
            exp_bytes.push_back(a[15:8]);       exp_btag.push_back({tag, " R3 byte1"});
            exp_bytes.push_back({c, a[19:16]}); exp_btag.push_back({tag, " R4 byte2"});
            exp_bytes.push_back({szn, lm1});    exp_btag.push_back({tag, " R5 R6 byte3"});
            if (is_w)
                for (int i = 0; i < len; i++) begin
                    exp_bytes.push_back(req_data[8*i +: 8]);
                    exp_btag.push_back({tag, " R7 payload"});
                end
            if (st == 8'd1 || st == 8'd2 || st == 8'd3) begin
                e = 3'(st); rp = 4'd0; cnt = 0;
            end else begin
                e = 3'd0; rp = st[7:4];
                cnt = is_w ? len : ((int'(rl) < len) ? int'(rl) : len);
            end
        end
        exp_res.push_back({e, rp, 5'(cnt)});
        exp_rtag.push_back({tag, " R8 R9 R10"});
        @(negedge clk);
        check(req_ready, "R11", "req_ready when idle", int'(req_ready), 1);
        req_addr  = a;
        req_cmd   = c;
        req_len   = 5'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (sent) begin
            while (exp_bytes.size() != 0) @(negedge clk);
            @(negedge clk);
            rsp_status = st;
            rsp_len    = rl;
            rsp_valid  = 1'b1;
            @(negedge clk);
            rsp_valid  = 1'b0;
        end
        while (exp_res.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "reset req_ready", int'(req_ready), 1);
        check(tx_valid == 1'b0, "R11", "reset tx_valid", int'(tx_valid), 0);
        check(done == 1'b0, "R11", "reset done", int'(done), 0);

        run_req(20'h12345, 4'h8, 3,  8'h00, 8'd0,  "R7 native write");
        run_req(20'hABCDE, 4'h9, 16, 8'h00, 8'd20, "R10 read clip");
        run_req(20'h00F0F, 4'h5, 4,  8'h20, 8'd2,  "R9 i2c read mot");
        run_req(20'h54321, 4'h0, 0,  8'h00, 8'd0,  "R6 bare write");
        run_req(20'h0BEEF, 4'h1, 0,  8'h00, 8'd5,  "R6 bare read");
        run_req(20'hFFFFF, 4'h4, 16, 8'h00, 8'd0,  "R6 write len16 wrap");
        run_req(20'h13579, 4'h8, 12, 8'h30, 8'd0,  "R6 write len12 wrap");
        run_req(20'h2468A, 4'h9, 8,  8'h01, 8'd8,  "R8 timeout");
        run_req(20'h2468B, 4'h8, 2,  8'h02, 8'd0,  "R8 flags");
        run_req(20'h2468C, 4'hD, 1,  8'h03, 8'd1,  "R8 general");
        run_req(20'h11111, 4'h9, 5,  8'h11, 8'd3,  "R8 R9 status 0x11");
        run_req(20'h33333, 4'h8, 17, 8'h00, 8'd0,  "R1 oversize");
        run_req(20'h44444, 4'hA, 2,  8'h00, 8'd0,  "R2 bad cmd A");
        run_req(20'h55555, 4'h2, 1,  8'h00, 8'd0,  "R2 bad cmd 2");
        run_req(20'h66666, 4'hE, 20, 8'h00, 8'd0,  "R1 R2 oversize first");
        run_req(20'h77777, 4'h0, 7,  8'hF0, 8'd0,  "R7 i2c write");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL R11 watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule